// File: doc/BRIEF.md
# Link-side controller for an 8-bit shared-bus PHY

This block sits on the link side of a narrow, bidirectional data bus shared with an external PHY. The PHY supplies the clock, and every register here runs on its rising edge. The PHY decides who owns the bus through a direction input. While that input is low, the link drives the bus, and the link's data output must be all zeros whenever it has nothing to send. While that input is high, the PHY drives bytes toward the link. Any clock in which the direction input differs from its value at the previous edge is a dead turnaround cycle: nothing is driven and nothing is captured.

A transmit client hands packet bytes over a valid/ready stream. The first byte of each packet is a non-zero command byte that opens the transfer. A throttle input from the PHY tells the link when the byte on the bus has been taken, so the link can present the next one. A prefetch register holds the following byte, which lets the output advance one edge after the throttle is sampled without a combinational path to the bus. When the PHY has taken the final byte, the link drives zeros and pulses an end-of-packet output for one clock. If the PHY claims the bus in the middle of a packet, or the client has no byte ready when one is needed, the packet is dropped and an abort pulse tells the client. On the receive side, each byte the PHY qualifies is delivered on a data/valid pair one clock later. This interface has no back-pressure.

Top module: `phy_link_ctrl`

## Requirements
- R1: While `rst_i` is high (synchronous reset), `link_dout_o` is 0, and `link_oe_o`, `link_end_o`, `rx_valid_o`, `tx_ready_o` and `tx_abort_o` are all 0.
- R2: `link_oe_o` is 1 exactly when all three hold: `rst_i` is low, `phy_owns_i` is low now, and `phy_owns_i` was low at the previous clock edge. During reset the edge register is loaded as if `phy_owns_i` were high, so `link_oe_o` is 0 in the first clock after reset.
- R3: While the link is idle, `link_dout_o` is 0. A stream handshake in idle with a non-zero byte places that byte on `link_dout_o` at the next edge and opens a packet. A handshake carrying byte 0 is consumed and discarded, and the link stays idle.
- R4: During a packet, if `phy_step_i` is high while the link owns the bus, the next packet byte appears on `link_dout_o` at the next edge. The byte comes from the prefetch register, or from the stream in that same cycle when the prefetch register is empty. If `phy_step_i` is low, `link_dout_o` holds its value.
- R5: When `phy_step_i` is high while the byte flagged `tx_last_i` is on the bus, `link_dout_o` becomes 0 and `link_end_o` is 1 for exactly one clock, starting at the next edge.
- R6: If `phy_owns_i` is high now and was high at the previous edge, and `phy_step_i` is high, then `rx_data_o` equals `phy_din_i` and `rx_valid_o` is 1 one clock later. Otherwise `rx_valid_o` is 0, which covers the turnaround cycle and any cycle with `phy_owns_i` low.
- R7: If `phy_owns_i` is high during a packet, then at the next edge the link returns to idle and `link_dout_o` becomes 0. `tx_abort_o` pulses for one clock and `link_end_o` stays 0. This applies even when `phy_step_i` is high in the same cycle. Any prefetched byte is discarded and is never presented.
- R8: `tx_ready_o` is 0 whenever `link_oe_o` is 0, so no byte is taken while the PHY owns the bus or during turnaround. In idle with the bus owned, `tx_ready_o` is 1.
- R9: If `phy_step_i` is high while the link owns the bus, the byte on the bus is not the last, the prefetch register is empty and `tx_valid_i` is low, then the packet is aborted. This gives the same output behaviour as R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | PHY-supplied clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| phy_owns_i | input | 1 | Bus direction from the PHY, high = PHY drives |
| phy_step_i | input | 1 | PHY throttle / receive qualifier |
| phy_din_i | input | 8 | Sampled bus value |
| link_dout_o | output | 8 | Value the link drives onto the bus |
| link_oe_o | output | 1 | Output enable for the bus drivers |
| link_end_o | output | 1 | One-clock end-of-packet pulse |
| tx_data_i | input | 8 | Transmit stream byte |
| tx_valid_i | input | 1 | Transmit stream valid |
| tx_last_i | input | 1 | Marks the final byte of a packet |
| tx_ready_o | output | 1 | Transmit stream ready |
| tx_abort_o | output | 1 | One-clock pulse when a packet is dropped |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte strobe |

## Verification
Two collisions matter here. The first is the PHY claiming the bus in the same cycle that it raises the throttle against a byte in flight. The bench provokes it by raising both inputs together mid-packet and requires an abort with no end pulse and zeros on the output. The second is the throttle being high in the very cycle the direction flips toward the link. The bench holds the throttle high across each rising and falling direction edge and requires that no received byte comes out for that cycle. Outside those collisions, packet lengths and throttle patterns are swept, and each byte expected on the bus is computed from its index.

// File: rtl/phy_link_pkg.sv
package phy_link_pkg;

    localparam int unsigned LINK_BYTE_W = 8;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_STOP = 2'd2
    } tx_state_e;

endpackage

// File: rtl/phy_link_bus.sv
module phy_link_bus (
    input  logic clk_i,
    input  logic rst_i,
    input  logic owns_i,
    output logic owns_q_o,
    output logic owned_o,
    output logic oe_o
);

    typedef struct packed {
        logic owns;
    } bus_regs_t;

    bus_regs_t q, d;

    always_comb begin
        d      = q;
        d.owns = owns_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q.owns <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign owns_q_o = q.owns;
    assign owned_o  = !owns_i && !q.owns;
    assign oe_o     = !rst_i && !owns_i && !q.owns;

endmodule

// File: rtl/phy_link_rx.sv
module phy_link_rx #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              owns_i,
    input  logic              owns_q_i,
    input  logic              step_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } rx_regs_t;

    rx_regs_t q, d;

    always_comb begin
        d       = q;
        d.valid = owns_i && owns_q_i && step_i;
        if (d.valid) begin
            d.data = din_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data_o  = q.data;
    assign valid_o = q.valid;

endmodule

// File: rtl/phy_link_tx.sv
module phy_link_tx
    import phy_link_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              owns_i,
    input  logic              owned_i,
    input  logic              step_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    input  logic              tx_last_i,
    output logic              tx_ready_o,
    output logic              tx_abort_o,
    output logic [DATA_W-1:0] dout_o,
    output logic              end_o
);

    typedef struct packed {
        tx_state_e         state;
        logic [DATA_W-1:0] dout;
        logic              last;
        logic [DATA_W-1:0] pf_data;
        logic              pf_last;
        logic              pf_valid;
        logic              stop;
        logic              abort;
    } tx_regs_t;

    tx_regs_t q, d;
    logic     ready;
    logic     take;

    always_comb begin
        d       = q;
        d.stop  = 1'b0;
        d.abort = 1'b0;
        ready   = 1'b0;
        take    = 1'b0;
        unique case (q.state)
            TX_IDLE: begin
                ready = owned_i;
                take  = ready && tx_valid_i;
                d.dout = '0;
                if (take && (tx_data_i != '0)) begin
                    d.dout     = tx_data_i;
                    d.last     = tx_last_i;
                    d.pf_valid = 1'b0;
                    d.state    = TX_SEND;
                end
            end
            TX_SEND: begin
                ready = owned_i && !q.pf_valid && !q.last;
                take  = ready && tx_valid_i;
                if (owns_i) begin
                    d.state    = TX_IDLE;
                    d.dout     = '0;
                    d.pf_valid = 1'b0;
                    d.abort    = 1'b1;
                end else if (owned_i && step_i) begin
                    if (q.last) begin
                        d.state = TX_STOP;
                        d.dout  = '0;
                        d.stop  = 1'b1;
                    end else if (q.pf_valid) begin
                        d.dout     = q.pf_data;
                        d.last     = q.pf_last;
                        d.pf_valid = 1'b0;
                    end else if (take) begin
                        d.dout = tx_data_i;
                        d.last = tx_last_i;
                    end else begin
                        d.state = TX_IDLE;
                        d.dout  = '0;
                        d.abort = 1'b1;
                    end
                end else if (take) begin
                    d.pf_data  = tx_data_i;
                    d.pf_last  = tx_last_i;
                    d.pf_valid = 1'b1;
                end
            end
            TX_STOP: begin
                d.dout  = '0;
                d.state = TX_IDLE;
            end
            default: begin
                d.state = TX_IDLE;
                d.dout  = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tx_ready_o = ready && !rst_i;
    assign tx_abort_o = q.abort;
    assign dout_o     = q.dout;
    assign end_o      = q.stop;

endmodule

// File: rtl/phy_link_ctrl.sv
module phy_link_ctrl
    import phy_link_pkg::*;
#(
    parameter int unsigned DATA_W = LINK_BYTE_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              phy_owns_i,
    input  logic              phy_step_i,
    input  logic [DATA_W-1:0] phy_din_i,
    output logic [DATA_W-1:0] link_dout_o,
    output logic              link_oe_o,
    output logic              link_end_o,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    input  logic              tx_last_i,
    output logic              tx_ready_o,
    output logic              tx_abort_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o
);

    logic owns_q;
    logic owned;

    phy_link_bus u_bus (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .owns_i   (phy_owns_i),
        .owns_q_o (owns_q),
        .owned_o  (owned),
        .oe_o     (link_oe_o)
    );

    phy_link_tx #(.DATA_W(DATA_W)) u_tx (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .owns_i     (phy_owns_i),
        .owned_i    (owned),
        .step_i     (phy_step_i),
        .tx_data_i  (tx_data_i),
        .tx_valid_i (tx_valid_i),
        .tx_last_i  (tx_last_i),
        .tx_ready_o (tx_ready_o),
        .tx_abort_o (tx_abort_o),
        .dout_o     (link_dout_o),
        .end_o      (link_end_o)
    );

    phy_link_rx #(.DATA_W(DATA_W)) u_rx (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .owns_i   (phy_owns_i),
        .owns_q_i (owns_q),
        .step_i   (phy_step_i),
        .din_i    (phy_din_i),
        .data_o   (rx_data_o),
        .valid_o  (rx_valid_o)
    );

endmodule

// File: rtl/phy_link_ctrl_chk.sv
module phy_link_ctrl_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              phy_owns_i,
    input logic              phy_step_i,
    input logic [DATA_W-1:0] phy_din_i,
    input logic [DATA_W-1:0] link_dout_o,
    input logic              link_oe_o,
    input logic              link_end_o,
    input logic [DATA_W-1:0] tx_data_i,
    input logic              tx_valid_i,
    input logic              tx_last_i,
    input logic              tx_ready_o,
    input logic              tx_abort_o,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              rx_valid_o
);

    p_oe_yield_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        phy_owns_i |-> !link_oe_o);

    p_oe_turn_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(phy_owns_i) |-> !link_oe_o);

    p_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (link_oe_o && !phy_step_i && link_dout_o != '0) |=> $stable(link_dout_o));

    p_end_pulse_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        link_end_o |=> !link_end_o);

    p_end_cause_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        link_end_o |-> ($past(phy_step_i) && link_dout_o == '0));

    p_rx_turn_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(phy_owns_i) |=> !rx_valid_o);

    p_rx_cause_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        rx_valid_o |-> $past(phy_owns_i && phy_step_i));

    p_abort_cause_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_abort_o |-> (($past(phy_owns_i) || $past(phy_step_i)) && link_dout_o == '0));

    p_ready_gate_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_ready_o |-> link_oe_o);

endmodule

bind phy_link_ctrl phy_link_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/phy_link_ctrl_bench.sv
module phy_link_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       owns, step;
    logic [7:0] din;
    logic [7:0] dout;
    logic       oe, lend;
    logic [7:0] txd;
    logic       txv, txl, txr, txa;
    logic [7:0] rxd;
    logic       rxv;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    phy_link_ctrl u_phy_link_ctrl (
        .clk_i(clk), .rst_i(rst), .phy_owns_i(owns), .phy_step_i(step),
        .phy_din_i(din), .link_dout_o(dout), .link_oe_o(oe), .link_end_o(lend),
        .tx_data_i(txd), .tx_valid_i(txv), .tx_last_i(txl), .tx_ready_o(txr),
        .tx_abort_o(txa), .rx_data_o(rxd), .rx_valid_o(rxv)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] pkt_byte(input int len, input int i);
        return 8'((len * 53 + i * 29 + 7) | 1);
    endfunction

    task automatic tx_packet(input int len, input logic [3:0] pat);
        int  sent;
        int  onbus;
        int  c;
        bit  done;
        bit  hs;
        bit  nx;
        sent = 0; c = 0; done = 0;
        txv = 1'b1; txd = pkt_byte(len, 0); txl = (len == 1);
        #1 hs = txr;
        chk("R3 ready in idle", {31'd0, hs}, 1);
        tick();
        sent = 1;
        onbus = 0;
        chk("R3 command on bus", {24'd0, dout}, {24'd0, pkt_byte(len, 0)});
        while (!done && c < 40) begin
            step = pat[c % 4];
            c++;
            txv = (sent < len);
            txd = pkt_byte(len, sent);
            txl = (sent == len - 1);
            #1 hs = txr && txv;
            nx = step;
            tick();
            if (hs) sent++;
            if (nx) begin
                if (onbus == len - 1) begin
                    chk("R5 end pulse", {31'd0, lend}, 1);
                    chk("R5 zero after last", {24'd0, dout}, 0);
                    done = 1;
                end else begin
                    onbus++;
                    chk("R4 advance", {24'd0, dout}, {24'd0, pkt_byte(len, onbus)});
                    chk("R4 no early end", {31'd0, lend}, 0);
                end
            end else begin
                chk("R4 hold", {24'd0, dout}, {24'd0, pkt_byte(len, onbus)});
            end
            chk("R9 no abort", {31'd0, txa}, 0);
        end
        step = 1'b0; txv = 1'b0; txl = 1'b0;
        tick();
        chk("R5 single pulse", {31'd0, lend}, 0);
        chk("R3 idle zero", {24'd0, dout}, 0);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [3:0] pats [4];
        bit hs;
        pats[0] = 4'b1111; pats[1] = 4'b0101; pats[2] = 4'b1000; pats[3] = 4'b0110;
        rst = 1'b1; owns = 1'b0; step = 1'b0; din = '0;
        txd = '0; txv = 1'b0; txl = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 dout", {24'd0, dout}, 0);
        chk("R1 oe", {31'd0, oe}, 0);
        chk("R1 end", {31'd0, lend}, 0);
        chk("R1 rx_valid", {31'd0, rxv}, 0);
        chk("R1 ready", {31'd0, txr}, 0);
        chk("R1 abort", {31'd0, txa}, 0);
        rst = 1'b0;
        #1 chk("R2 oe first cycle", {31'd0, oe}, 0);
        tick();
        chk("R2 oe owned", {31'd0, oe}, 1);
        chk("R8 ready owned", {31'd0, txr}, 1);

        // R2 / R8 sweep over (previous, current) direction
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                owns = a[0];
                tick();
                owns = b[0];
                #1;
                chk("R2 oe sweep", {31'd0, oe}, {31'd0, !(a[0] | b[0])});
                chk("R8 ready sweep", {31'd0, txr}, {31'd0, !(a[0] | b[0])});
                tick();
            end
        end
        owns = 1'b0;
        tick(); tick();

        // R3 zero command byte is dropped
        txv = 1'b1; txd = 8'h00; txl = 1'b0;
        #1 hs = txr;
        chk("R3 zero handshake", {31'd0, hs}, 1);
        tick();
        txv = 1'b0; step = 1'b1;
        chk("R3 zero stays idle", {24'd0, dout}, 0);
        tick();
        step = 1'b0;
        chk("R3 idle ignores step", {24'd0, dout}, 0);
        chk("R3 no end", {31'd0, lend}, 0);
        chk("R3 no abort", {31'd0, txa}, 0);
        tick();

        // R4 / R5 sweep over lengths and throttle patterns
        for (int len = 1; len <= 5; len++) begin
            for (int p = 0; p < 4; p++) begin
                tx_packet(len, pats[p]);
            end
        end

        // R6 receive sweep with throttle high on direction edges
        for (int k = 0; k < 8; k++) begin
            logic pv;
            logic [7:0] pd;
            owns = 1'b1; step = 1'b1; din = 8'hA0 + 8'(k);
            #1 chk("R8 ready while phy owns", {31'd0, txr}, 0);
            tick();
            chk("R6 turnaround ignored", {31'd0, rxv}, 0);
            for (int j = 0; j < 4; j++) begin
                step = ((k + j) % 3 != 0);
                din  = 8'(k * 16 + j + 1);
                pv = step; pd = din;
                tick();
                chk("R6 rx valid", {31'd0, rxv}, {31'd0, pv});
                if (pv) chk("R6 rx data", {24'd0, rxd}, {24'd0, pd});
            end
            owns = 1'b0; step = 1'b1; din = 8'hFF;
            tick();
            chk("R6 falling edge ignored", {31'd0, rxv}, 0);
            step = 1'b0;
            tick();
            chk("R6 link owns no rx", {31'd0, rxv}, 0);
        end
        tick();

        // R7 abort: phy claims bus together with a throttle pulse
        txv = 1'b1; txd = 8'h5A; txl = 1'b0;
        tick();
        chk("R7 first byte", {24'd0, dout}, 8'h5A);
        txd = 8'h33;
        tick();
        txv = 1'b0; owns = 1'b1; step = 1'b1;
        #1 chk("R8 no ready on claim", {31'd0, txr}, 0);
        tick();
        step = 1'b0;
        chk("R7 dout zero", {24'd0, dout}, 0);
        chk("R7 abort pulse", {31'd0, txa}, 1);
        chk("R7 no end", {31'd0, lend}, 0);
        tick();
        chk("R7 abort single", {31'd0, txa}, 0);
        owns = 1'b0;
        #1 chk("R8 no ready in turnaround", {31'd0, txr}, 0);
        tick();
        chk("R8 ready after turnaround", {31'd0, txr}, 1);
        tick();
        chk("R7 prefetch dropped", {24'd0, dout}, 0);

        // R9 underrun
        txv = 1'b1; txd = 8'h44; txl = 1'b0;
        tick();
        chk("R9 first byte", {24'd0, dout}, 8'h44);
        txv = 1'b0; step = 1'b1;
        tick();
        step = 1'b0;
        chk("R9 abort pulse", {31'd0, txa}, 1);
        chk("R9 dout zero", {24'd0, dout}, 0);
        chk("R9 no end", {31'd0, lend}, 0);
        tick();
        chk("R9 abort single", {31'd0, txa}, 0);

        report();
        $finish;
    end

endmodule